// File: doc/BRIEF.md
# Peekable Synchronous Queue

This block is a single-clock first-in-first-out queue whose word width and number of slots are set by parameters. A producer writes words at the tail through a push port. A consumer takes words from the head through a pop port. The head word is always shown on the pop data output, so the consumer sees the word before it pops it. Push and pop may both be requested in the same clock cycle.

Besides the usual empty and full indications, the queue reports a half-full flag, the exact number of stored words, and a flag that rises once that number reaches a threshold supplied on an input. A side port returns the word at any position counted from the head, one cycle after the position is presented. Reading it never moves the queue.

The control is a three-state machine (empty, partly filled, full) driving a pointer-and-counter datapath.

Top module: `peek_fifo`

## Requirements
- R1: While reset is high at a clock edge, the level goes to 0 and empty_o is 1. After the first edge with reset low, half_o, full_o and level_hit_o are 0 (with level_thr_i nonzero).
- R2: Words leave in the order they were accepted. pop_data_o shows the oldest stored word whenever the queue is not empty.
- R3: A push while the queue is full and no pop is requested is ignored. The level and the stored words do not change.
- R4: A pop while the queue is empty is ignored, and the level stays 0.
- R5: A push and a pop in the same cycle leave the level unchanged when the queue holds at least one word, including when it is full. When the queue is empty, only the push takes effect.
- R6: level_o equals the number of accepted pushes minus the number of accepted pops since reset, and it updates on the clock edge that accepts them.
- R7: empty_o is 1 exactly when the level is 0, and full_o is 1 exactly when the level equals DEPTH.
- R8: half_o is 1 exactly when twice the level is at least DEPTH.
- R9: level_hit_o is 1 exactly when level_o >= level_thr_i. It follows a change of the threshold in the same cycle.
- R10: peek_data_o, sampled after a clock edge, holds the word at offset peek_idx_i from the head as it was before that edge. Offset 0 is the oldest word, and the position wraps modulo DEPTH.
- R11: Driving peek_idx_i changes neither the level nor the order or contents of the words that are later popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Request to write push_data_i at the tail |
| push_data_i | input | DATA_W | Word to write |
| pop_i | input | 1 | Request to remove the head word |
| pop_data_o | output | DATA_W | Current head word |
| peek_idx_i | input | clog2(DEPTH) | Offset from the head for the side read |
| peek_data_o | output | DATA_W | Registered word at the requested offset |
| level_thr_i | input | clog2(DEPTH+1) | Occupancy threshold |
| level_o | output | clog2(DEPTH+1) | Number of stored words |
| empty_o | output | 1 | Queue holds no word |
| half_o | output | 1 | Queue holds at least half of DEPTH |
| full_o | output | 1 | Queue holds DEPTH words |
| level_hit_o | output | 1 | level_o has reached level_thr_i |

## Verification
A push and a pop can land in the same cycle. The bench provokes this in all three machine states: empty, partly filled and full. At the full boundary it also follows a blocked push with a combined push and pop. It judges each case by the level after the edge and by a reference queue model that predicts every head word seen later. A side read and a tail write can also coincide. The bench checks that the registered peek word reflects contents from before the edge, and that words popped afterwards are undisturbed.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      ST_EMPTY = 2'd0,
      ST_MID   = 2'd1,
      ST_FULL  = 2'd2
   } pf_state_e;

endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
   import pf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             push_i,
   input  logic             pop_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic [CNT_W-1:0] cnt_o,
   output pf_state_e        state_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
   localparam bit               POW2     = (DEPTH == (1 << PTR_W));

   pf_state_e        state_q, state_nx;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [PTR_W-1:0] head_q, tail_q, head_inc, tail_inc;
   logic             do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_free
         assign head_inc = head_q + 1'b1;
         assign tail_inc = tail_q + 1'b1;
      end else begin : g_wrap_cmp
         assign head_inc = (head_q == LAST_PTR) ? '0 : head_q + 1'b1;
         assign tail_inc = (tail_q == LAST_PTR) ? '0 : tail_q + 1'b1;
      end
   endgenerate

   always_comb begin
      do_pop  = pop_i && (state_q != ST_EMPTY);
      do_push = push_i && ((state_q != ST_FULL) || do_pop);
      cnt_nx  = cnt_q;
      case ({do_push, do_pop})
         2'b10:   cnt_nx = cnt_q + 1'b1;
         2'b01:   cnt_nx = cnt_q - 1'b1;
         default: cnt_nx = cnt_q;
      endcase
      if (cnt_nx == '0)
         state_nx = ST_EMPTY;
      else if (cnt_nx == FULL_CNT)
         state_nx = ST_FULL;
      else
         state_nx = ST_MID;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_EMPTY;
         cnt_q   <= '0;
         head_q  <= '0;
         tail_q  <= '0;
      end else begin
         state_q <= state_nx;
         cnt_q   <= cnt_nx;
         if (do_pop)  head_q <= head_inc;
         if (do_push) tail_q <= tail_inc;
      end
   end

   assign wr_en_o = do_push;
   assign head_o  = head_q;
   assign tail_o  = tail_q;
   assign cnt_o   = cnt_q;
   assign state_o = state_q;

   p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q == FULL_CNT && push_i && !pop_i) |=> (cnt_q == FULL_CNT && $stable(tail_q)));

   p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q == '0 && pop_i && !push_i) |=> (cnt_q == '0 && $stable(head_q)));

   p_pair_holds_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q != '0 && push_i && pop_i) |=> $stable(cnt_q));

   p_level_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= FULL_CNT);

   p_state_level_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      ((state_q == ST_EMPTY) == (cnt_q == '0)) && ((state_q == ST_FULL) == (cnt_q == FULL_CNT)));

endmodule

// File: rtl/pf_store.sv
module pf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_ptr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  head_i,
   output logic [DATA_W-1:0] head_data_o,
   input  logic [PTR_W-1:0]  peek_idx_i,
   output logic [DATA_W-1:0] peek_data_o
);

   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  peek_addr;
   logic [DATA_W-1:0] peek_q;

   generate
      if (POW2) begin : g_peek_trunc
         assign peek_addr = head_i + peek_idx_i;
      end else begin : g_peek_fold
         logic [PTR_W:0] sum;
         assign sum       = {1'b0, head_i} + {1'b0, peek_idx_i};
         assign peek_addr = (sum >= (PTR_W + 1)'(DEPTH)) ? PTR_W'(sum - (PTR_W + 1)'(DEPTH))
                                                         : sum[PTR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (wr_en_i) mem_q[wr_ptr_i] <= wr_data_i;
      peek_q <= mem_q[peek_addr];
   end

   assign head_data_o = mem_q[head_i];
   assign peek_data_o = peek_q;

endmodule

// File: rtl/peek_fifo.sv
module peek_fifo
   import pf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   input  logic [PTR_W-1:0]  peek_idx_i,
   output logic [DATA_W-1:0] peek_data_o,
   input  logic [CNT_W-1:0]  level_thr_i,
   output logic [CNT_W-1:0]  level_o,
   output logic              empty_o,
   output logic              half_o,
   output logic              full_o,
   output logic              level_hit_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("peek_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("peek_fifo: DATA_W must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W:0] DEPTH_X = (CNT_W + 1)'(DEPTH);

   logic             wr_en;
   logic [PTR_W-1:0] head, tail;
   logic [CNT_W-1:0] cnt;
   pf_state_e        state;

   pf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .push_i  (push_i),
      .pop_i   (pop_i),
      .wr_en_o (wr_en),
      .head_o  (head),
      .tail_o  (tail),
      .cnt_o   (cnt),
      .state_o (state)
   );

   pf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk_i       (clk_i),
      .wr_en_i     (wr_en),
      .wr_ptr_i    (tail),
      .wr_data_i   (push_data_i),
      .head_i      (head),
      .head_data_o (pop_data_o),
      .peek_idx_i  (peek_idx_i),
      .peek_data_o (peek_data_o)
   );

   assign level_o     = cnt;
   assign empty_o     = (state == ST_EMPTY);
   assign full_o      = (state == ST_FULL);
   assign half_o      = ({cnt, 1'b0} >= DEPTH_X);
   assign level_hit_o = (cnt >= level_thr_i);

   p_flags_apart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !(empty_o && full_o));

   p_full_implies_half_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      full_o |-> half_o);

   p_empty_no_half_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      empty_o |-> !half_o);

endmodule

// File: tb/tb_peek_fifo.sv
module tb_peek_fifo;

   localparam int DW = 8;
   localparam int DP = 8;
   localparam int PW = $clog2(DP);
   localparam int CW = $clog2(DP + 1);
   localparam int NV = 22;

   // vector: push, pop, data[7:0], expected level after the edge[3:0]
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'h11, 4'd1}, {1'b1, 1'b0, 8'h12, 4'd2},
      {1'b1, 1'b0, 8'h13, 4'd3}, {1'b1, 1'b0, 8'h14, 4'd4},
      {1'b1, 1'b0, 8'h15, 4'd5}, {1'b1, 1'b0, 8'h16, 4'd6},
      {1'b1, 1'b0, 8'h17, 4'd7}, {1'b1, 1'b0, 8'h18, 4'd8},
      {1'b1, 1'b0, 8'hEE, 4'd8},
      {1'b1, 1'b1, 8'h19, 4'd8},
      {1'b0, 1'b1, 8'h00, 4'd7}, {1'b0, 1'b1, 8'h00, 4'd6},
      {1'b0, 1'b1, 8'h00, 4'd5},
      {1'b1, 1'b1, 8'h1A, 4'd5},
      {1'b0, 1'b1, 8'h00, 4'd4}, {1'b0, 1'b1, 8'h00, 4'd3},
      {1'b0, 1'b1, 8'h00, 4'd2}, {1'b0, 1'b1, 8'h00, 4'd1},
      {1'b0, 1'b1, 8'h00, 4'd0},
      {1'b0, 1'b1, 8'h00, 4'd0},
      {1'b1, 1'b1, 8'h1B, 4'd1},
      {1'b0, 1'b1, 8'h00, 4'd0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          push = 1'b0, pop = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data, peek_data;
   logic [PW-1:0] peek_idx = '0;
   logic [CW-1:0] thr = CW'(5);
   logic [CW-1:0] level;
   logic          empty, half, full, hit;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] mq [$];

   always #5 clk = ~clk;

   peek_fifo #(.DATA_W(DW), .DEPTH(DP)) dut (
      .clk_i(clk), .rst_i(rst), .push_i(push), .push_data_i(push_data),
      .pop_i(pop), .pop_data_o(pop_data), .peek_idx_i(peek_idx),
      .peek_data_o(peek_data), .level_thr_i(thr), .level_o(level),
      .empty_o(empty), .half_o(half), .full_o(full), .level_hit_o(hit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic flags_chk();
      int n = mq.size();
      chk("R7 empty", 32'(empty), 32'(n == 0));
      chk("R7 full", 32'(full), 32'(n == DP));
      chk("R8 half", 32'(half), 32'(2 * n >= DP));
      chk("R9 threshold", 32'(hit), 32'(n >= int'(thr)));
   endtask

   // called right after a falling edge; returns right after the next one
   task automatic op(input logic p, input logic q, input logic [DW-1:0] d);
      bit pop_ok, push_ok;
      push = p; pop = q; push_data = d;
      #1;
      if (q && mq.size() > 0) chk("R2 head word", 32'(pop_data), 32'(mq[0]));
      @(posedge clk);
      @(negedge clk);
      pop_ok  = q && (mq.size() > 0);
      push_ok = p && ((mq.size() < DP) || pop_ok);
      if (pop_ok)  void'(mq.pop_front());
      if (push_ok) mq.push_back(d);
      push = 1'b0; pop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 level", 32'(level), 0);
      chk("R1 empty", 32'(empty), 1);
      chk("R1 half", 32'(half), 0);
      chk("R1 full", 32'(full), 0);
      chk("R1 thr flag", 32'(hit), 0);

      // table: R3 blocked push, R4 empty pop, R5 pairs, R6 level
      for (int i = 0; i < NV; i++) begin
         op(VEC[i][13], VEC[i][12], VEC[i][11:4]);
         chk($sformatf("R6 level step %0d", i), 32'(level), 32'(VEC[i][3:0]));
         flags_chk();
      end

      // R10 peek with wrap: fill A0..A5, drop two
      for (int k = 0; k < 6; k++) op(1'b1, 1'b0, DW'(8'hA0 + k));
      op(1'b0, 1'b1, '0);
      op(1'b0, 1'b1, '0);
      peek_idx = '0;
      @(posedge clk); @(negedge clk);
      chk("R10 peek offset 0", 32'(peek_data), 32'h A2);
      peek_idx = PW'(3);
      #1;
      chk("R10 peek one-cycle latency", 32'(peek_data), 32'h A2);
      @(posedge clk); @(negedge clk);
      chk("R10 peek offset 3 wraps", 32'(peek_data), 32'h A5);
      peek_idx = PW'(1);
      @(posedge clk); @(negedge clk);
      chk("R10 peek offset 1", 32'(peek_data), 32'h A3);

      // R10 peek during a push sees pre-edge contents at new slot
      peek_idx = PW'(4);
      op(1'b1, 1'b0, 8'hB0);
      chk("R10 peek before write", 32'(peek_data) == 32'h B0 ? 0 : 1, 1);

      // R11 peeking left the queue alone
      chk("R11 level after peeks", 32'(level), 5);
      op(1'b0, 1'b1, '0);
      chk("R11 order after peeks", 32'(level), 4);

      // R9 threshold tracks input in the same cycle
      thr = CW'(4); #1;
      chk("R9 equal to threshold", 32'(hit), 1);
      thr = CW'(5); #1;
      chk("R9 below threshold", 32'(hit), 0);
      thr = CW'(5);

      // R2 drain with data check
      while (mq.size() > 0) op(1'b0, 1'b1, '0);
      chk("R2 drained", 32'(empty), 1);

      // R1 reset in the middle of traffic
      op(1'b1, 1'b0, 8'hC1);
      op(1'b1, 1'b0, 8'hC2);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      mq.delete();
      chk("R1 mid-run level", 32'(level), 0);
      chk("R1 mid-run empty", 32'(empty), 1);
      op(1'b1, 1'b0, 8'hD7);
      chk("R2 after reset head", 32'(pop_data), 32'h D7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule